// File: doc/BRIEF.md
# Receiver PHY bring-up sequencer

This block is a hardware state machine that takes a multi-lane high-speed serial receiver PHY from reset to normal operation with no software involved in each step. A one-cycle start pulse carries a lane count and a per-lane line rate in Mbps. The sequencer turns the rate into a 6-bit frequency-range code through an ordered table of upper bounds. If the request is valid, it drives the lane control vectors. It then raises the test clock, holds the test clear for a timed interval, waits a second interval of the same length, and issues seven (code, data) writes over a bit-level test-port handshake. It ends with a one-cycle done pulse.

A request that cannot be served produces a one-cycle error pulse and leaves the PHY outputs untouched. A power-off input switches every lane off at any time and abandons any sequence in progress. Both timed intervals are counted in clock cycles, derived from a cycles-per-microsecond parameter.

Top module: `rxphy_bringup_seq`

## Requirements
- R1: The range code is taken from the first entry, in this order, whose upper bound is greater than or equal to the rate (bound:code, code in hex): 89:00 99:10 109:20 129:01 139:11 149:21 169:02 179:12 199:22 219:03 239:13 249:23 269:04 299:14 329:05 359:15 399:25 449:06 499:16 549:07 599:17 649:08 699:18 749:09 799:19 849:29 899:39 949:0a 999:1a 1049:2a 1099:3a 1149:0b 1199:1b 1249:2b 1299:3b 1349:0c 1399:1c 1449:2c 1500:3c.
- R2: A request is rejected in any of three cases: the rate exceeds 1500, the matched code is 0x00, or the lane count lies outside 1..4. A rejected request gives a one-cycle error_o pulse. It produces no test-port write and leaves lane_en_o unchanged.
- R3: On an accepted request, before any test write, the sequencer clears force_rx_o and force_stop_o, sets turn_req_o to 0 and turn_dis_o to 0xF, and sets lane_en_o to the low N bits set for N lanes.
- R4: tst_clk_o is already high whenever tst_clr_o is high. tst_clr_o stays high for at least CLR_US*CYC_PER_US cycles (at most two more). At least that many cycles then pass after it falls before tst_en_o first rises.
- R5: In each write, tst_din_o holds the code and tst_en_o is high when tst_clk_o falls. tst_din_o then holds the data and tst_en_o is low when tst_clk_o rises again. Each step of the handshake lasts HOLD_CYC cycles.
- R6: The writes come in this order, as (code, data): (0x34, 0); then codes 0x44, 0x54, 0x84 and 0x94, each with data equal to the range code shifted left by one; then (0x75, 0x04); and last (0x00, 0).
- R7: busy_o is high from the cycle after an accepted start until the cycle after done_o or error_o. done_o is a one-cycle pulse that follows the last write.
- R8: A start pulse while busy_o is high is ignored. The running sequence keeps the rate and the lane count it was started with.
- R9: power_off_i clears lane_en_o to zero in the next cycle from any state. It abandons a running sequence without done_o, and it drops tst_clr_o and tst_en_o.
- R10: After reset, lane_en_o, turn_req_o, turn_dis_o, tst_clr_o, tst_en_o, tst_clk_o, busy_o, done_o and error_o are 0, and force_rx_o and force_stop_o are 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to bring the PHY up |
| lanes_i | input | 3 | Number of active lanes, 1 to 4 |
| rate_i | input | RATE_W | Per-lane line rate in Mbps |
| power_off_i | input | 1 | Switch all lanes off and abandon any sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: bring-up complete |
| error_o | output | 1 | One-cycle pulse: request rejected |
| lane_en_o | output | LANES | Per-lane enable |
| force_rx_o | output | LANES | Force-receive control per lane |
| force_stop_o | output | LANES | Force-stop-state control per lane |
| turn_req_o | output | LANES | Turnaround request per lane |
| turn_dis_o | output | LANES | Turnaround disable per lane |
| tst_clr_o | output | 1 | Test-port clear |
| tst_clk_o | output | 1 | Test-port clock |
| tst_en_o | output | 1 | Test-port enable (code phase) |
| tst_din_o | output | 8 | Test-port data bus |

## Verification
The hardest situations to reach from the ports are a second start, or a power-off, that arrives in the middle of the timed clear or the write train. These cannot be produced by driving one request and waiting for it to finish. The bench therefore starts a valid request and, at a fixed cycle offset, drives either a conflicting start or a power-off. It then checks that the captured write train still carries the first request's range code, or that no write and no done appear at all. The rate boundaries on both sides of 89, 99, 129, 1499 and 1500 are driven directly, because the zero code at the bottom of the table and the end of the table both have to produce an error.

// File: rtl/rxphy_seq_pkg.sv
package rxphy_seq_pkg;

  localparam int NUM_RANGES = 39;
  localparam int NUM_WRITES = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_SETUP, S_HOLD, S_WAIT, S_WRITE, S_DONE, S_ERR
  } seq_state_e;

  localparam logic [10:0] RANGE_HI [NUM_RANGES] = '{
    11'd89,   11'd99,   11'd109,  11'd129,  11'd139,  11'd149,  11'd169,  11'd179,
    11'd199,  11'd219,  11'd239,  11'd249,  11'd269,  11'd299,  11'd329,  11'd359,
    11'd399,  11'd449,  11'd499,  11'd549,  11'd599,  11'd649,  11'd699,  11'd749,
    11'd799,  11'd849,  11'd899,  11'd949,  11'd999,  11'd1049, 11'd1099, 11'd1149,
    11'd1199, 11'd1249, 11'd1299, 11'd1349, 11'd1399, 11'd1449, 11'd1500};

  localparam logic [5:0] RANGE_CODE [NUM_RANGES] = '{
    6'h00, 6'h10, 6'h20, 6'h01, 6'h11, 6'h21, 6'h02, 6'h12,
    6'h22, 6'h03, 6'h13, 6'h23, 6'h04, 6'h14, 6'h05, 6'h15,
    6'h25, 6'h06, 6'h16, 6'h07, 6'h17, 6'h08, 6'h18, 6'h09,
    6'h19, 6'h29, 6'h39, 6'h0a, 6'h1a, 6'h2a, 6'h3a, 6'h0b,
    6'h1b, 6'h2b, 6'h3b, 6'h0c, 6'h1c, 6'h2c, 6'h3c};

  // Returns {hit, code}; scanning from the top lets the lowest matching entry win.
  function automatic logic [6:0] range_lookup(input logic [15:0] rate);
    logic [6:0] res;
    res = 7'd0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (rate <= {5'd0, RANGE_HI[i]}) res = {1'b1, RANGE_CODE[i]};
    end
    return res;
  endfunction

  function automatic logic [7:0] wr_code(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h34;
      3'd1:    return 8'h44;
      3'd2:    return 8'h54;
      3'd3:    return 8'h84;
      3'd4:    return 8'h94;
      3'd5:    return 8'h75;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] wr_data(input logic [2:0] idx, input logic [5:0] code);
    case (idx)
      3'd1, 3'd2, 3'd3, 3'd4: return {1'b0, code, 1'b0};
      3'd5:                   return 8'h04;
      default:                return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rxphy_rate_lookup.sv
module rxphy_rate_lookup #(
  parameter int RATE_W = 12
) (
  input  logic [RATE_W-1:0] rate_i,
  output logic              hit_o,
  output logic [5:0]        code_o
);
  import rxphy_seq_pkg::*;

  logic [6:0] res;

  always_comb begin
    res    = range_lookup(16'(rate_i));
    hit_o  = res[6];
    code_o = res[5:0];
  end
endmodule

// File: rtl/rxphy_us_timer.sv
module rxphy_us_timer #(
  parameter int CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load_i)           cnt_n = CNT_W'(CYCLES - 1);
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rxphy_test_writer.sv
module rxphy_test_writer #(
  parameter int HOLD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_i,
  input  logic       clk_set_i,
  input  logic       go_i,
  input  logic [7:0] code_i,
  input  logic [7:0] data_i,
  output logic       ack_o,
  output logic       tst_clk_o,
  output logic       tst_en_o,
  output logic [7:0] tst_din_o
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic          act_q, act_n, ack_q, ack_n, clk_q, clk_n, en_q, en_n;
  logic [2:0]    ph_q, ph_n;
  logic [HW-1:0] cnt_q, cnt_n;
  logic [7:0]    din_q, din_n, dat_q, dat_n;

  always_comb begin
    act_n = act_q; ack_n = 1'b0; clk_n = clk_q; en_n = en_q;
    ph_n = ph_q; cnt_n = cnt_q; din_n = din_q; dat_n = dat_q;
    if (abort_i) begin
      act_n = 1'b0;
      en_n  = 1'b0;
    end else begin
      if (clk_set_i) clk_n = 1'b1;
      if (go_i && !act_q) begin
        act_n = 1'b1; ph_n = 3'd0; cnt_n = '0;
        din_n = code_i; dat_n = data_i; en_n = 1'b1;
      end else if (act_q) begin
        if (cnt_q == HW'(HOLD_CYC - 1)) begin
          cnt_n = '0;
          ph_n  = ph_q + 3'd1;
          case (ph_q)
            3'd0:    clk_n = 1'b0;
            3'd1:    en_n  = 1'b0;
            3'd2:    din_n = dat_q;
            3'd3:    clk_n = 1'b1;
            default: begin act_n = 1'b0; ack_n = 1'b1; end
          endcase
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; ack_q <= 1'b0; clk_q <= 1'b0; en_q <= 1'b0;
      ph_q <= 3'd0; cnt_q <= '0; din_q <= 8'd0; dat_q <= 8'd0;
    end else begin
      act_q <= act_n; ack_q <= ack_n; clk_q <= clk_n; en_q <= en_n;
      ph_q <= ph_n; cnt_q <= cnt_n; din_q <= din_n; dat_q <= dat_n;
    end
  end

  assign ack_o     = ack_q;
  assign tst_clk_o = clk_q;
  assign tst_en_o  = en_q;
  assign tst_din_o = din_q;

  // R5
  code_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tst_clk_o) |-> tst_en_o);
  // R5
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tst_clk_o) |-> !tst_en_o);
endmodule

// File: rtl/rxphy_bringup_seq.sv
module rxphy_bringup_seq #(
  parameter int CYC_PER_US = 200,
  parameter int CLR_US     = 100,
  parameter int HOLD_CYC   = 2,
  parameter int LANES      = 4,
  parameter int RATE_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        lanes_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              power_off_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic [LANES-1:0]  force_rx_o,
  output logic [LANES-1:0]  force_stop_o,
  output logic [LANES-1:0]  turn_req_o,
  output logic [LANES-1:0]  turn_dis_o,
  output logic              tst_clr_o,
  output logic              tst_clk_o,
  output logic              tst_en_o,
  output logic [7:0]        tst_din_o
);
  import rxphy_seq_pkg::*;

  localparam int          CLR_CYC = CYC_PER_US * CLR_US;
  localparam logic [2:0]  LAST_WR = 3'(NUM_WRITES - 1);

  seq_state_e       st_q, st_n;
  logic [5:0]       code_q, code_n;
  logic             hit_q, hit_n;
  logic [2:0]       lanes_q, lanes_n, idx_q, idx_n, go_idx;
  logic [LANES-1:0] len_q, len_n, frx_q, frx_n, fst_q, fst_n;
  logic [LANES-1:0] trq_q, trq_n, tds_q, tds_n, mask;
  logic             clr_q, clr_n;
  logic             lk_hit, tmr_zero, tmr_load, wr_go, wr_ack, clk_set;
  logic [5:0]       lk_code;

  rxphy_rate_lookup #(.RATE_W(RATE_W)) u_lookup (
    .rate_i(rate_i), .hit_o(lk_hit), .code_o(lk_code));

  rxphy_us_timer #(.CYCLES(CLR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .zero_o(tmr_zero));

  rxphy_test_writer #(.HOLD_CYC(HOLD_CYC)) u_writer (
    .clk(clk), .rst_n(rst_n), .abort_i(power_off_i), .clk_set_i(clk_set),
    .go_i(wr_go), .code_i(wr_code(go_idx)), .data_i(wr_data(go_idx, code_q)),
    .ack_o(wr_ack), .tst_clk_o(tst_clk_o), .tst_en_o(tst_en_o),
    .tst_din_o(tst_din_o));

  always_comb begin
    for (int i = 0; i < LANES; i++) mask[i] = (3'(i) < lanes_q);
  end

  always_comb begin
    tmr_load = (st_q == S_SETUP) || ((st_q == S_HOLD) && tmr_zero);
    clk_set  = (st_q == S_SETUP);
    wr_go    = !power_off_i &&
               (((st_q == S_WAIT) && tmr_zero) ||
                ((st_q == S_WRITE) && wr_ack && (idx_q != LAST_WR)));
    go_idx   = (st_q == S_WRITE) ? idx_q + 3'd1 : 3'd0;
  end

  always_comb begin
    st_n = st_q; code_n = code_q; hit_n = hit_q; lanes_n = lanes_q; idx_n = idx_q;
    len_n = len_q; frx_n = frx_q; fst_n = fst_q; trq_n = trq_q; tds_n = tds_q;
    clr_n = clr_q;
    if (power_off_i) begin
      st_n  = S_IDLE;
      len_n = '0;
      clr_n = 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          code_n = lk_code; hit_n = lk_hit; lanes_n = lanes_i; st_n = S_CHECK;
        end
        S_CHECK: begin
          if (!hit_q || code_q == 6'd0 || lanes_q == 3'd0 || lanes_q > 3'(LANES))
            st_n = S_ERR;
          else
            st_n = S_SETUP;
        end
        S_SETUP: begin
          frx_n = '0; fst_n = '0; trq_n = '0; tds_n = '1;
          len_n = mask; clr_n = 1'b1; st_n = S_HOLD;
        end
        S_HOLD: if (tmr_zero) begin
          clr_n = 1'b0; st_n = S_WAIT;
        end
        S_WAIT: if (tmr_zero) begin
          idx_n = 3'd0; st_n = S_WRITE;
        end
        S_WRITE: if (wr_ack) begin
          if (idx_q == LAST_WR) st_n = S_DONE;
          else                  idx_n = go_idx;
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; code_q <= '0; hit_q <= 1'b0; lanes_q <= '0; idx_q <= '0;
      len_q <= '0; frx_q <= '1; fst_q <= '1; trq_q <= '0; tds_q <= '0;
      clr_q <= 1'b0;
    end else begin
      st_q <= st_n; code_q <= code_n; hit_q <= hit_n; lanes_q <= lanes_n;
      idx_q <= idx_n; len_q <= len_n; frx_q <= frx_n; fst_q <= fst_n;
      trq_q <= trq_n; tds_q <= tds_n; clr_q <= clr_n;
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign done_o       = (st_q == S_DONE);
  assign error_o      = (st_q == S_ERR);
  assign lane_en_o    = len_q;
  assign force_rx_o   = frx_q;
  assign force_stop_o = fst_q;
  assign turn_req_o   = trq_q;
  assign turn_dis_o   = tds_q;
  assign tst_clr_o    = clr_q;

  // R4
  clr_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tst_clr_o |-> tst_clk_o);
  // R9
  power_off_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    power_off_i |=> (lane_en_o == '0) && !done_o);
  // R8
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !power_off_i) |=> $stable(code_q) && $stable(lanes_q));
  // R7
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(wr_ack));
endmodule

// File: tb/test_rxphy_bringup_seq.sv
module test_rxphy_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int CLRUS      = 100;
  localparam int CLR_EXP    = CPU * CLRUS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] lanes_i = 3'd0;
  logic [11:0] rate_i = 12'd0;
  logic       power_off_i = 1'b0;
  logic       busy_o, done_o, error_o, tst_clr_o, tst_clk_o, tst_en_o;
  logic [3:0] lane_en_o, force_rx_o, force_stop_o, turn_req_o, turn_dis_o;
  logic [7:0] tst_din_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  rxphy_bringup_seq #(.CYC_PER_US(CPU), .CLR_US(CLRUS), .HOLD_CYC(2),
                      .LANES(4), .RATE_W(12)) i_rxphy_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .lanes_i(lanes_i),
    .rate_i(rate_i), .power_off_i(power_off_i), .busy_o(busy_o),
    .done_o(done_o), .error_o(error_o), .lane_en_o(lane_en_o),
    .force_rx_o(force_rx_o), .force_stop_o(force_stop_o),
    .turn_req_o(turn_req_o), .turn_dis_o(turn_dis_o), .tst_clr_o(tst_clr_o),
    .tst_clk_o(tst_clk_o), .tst_en_o(tst_en_o), .tst_din_o(tst_din_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference table from R1
  function automatic int ref_code(input int rate);
    int hi [39] = '{89,99,109,129,139,149,169,179,199,219,239,249,269,299,329,
                    359,399,449,499,549,599,649,699,749,799,849,899,949,999,
                    1049,1099,1149,1199,1249,1299,1349,1399,1449,1500};
    int cd [39] = '{'h00,'h10,'h20,'h01,'h11,'h21,'h02,'h12,'h22,'h03,'h13,
                    'h23,'h04,'h14,'h05,'h15,'h25,'h06,'h16,'h07,'h17,'h08,
                    'h18,'h09,'h19,'h29,'h39,'h0a,'h1a,'h2a,'h3a,'h0b,'h1b,
                    'h2b,'h3b,'h0c,'h1c,'h2c,'h3c};
    for (int i = 0; i < 39; i++) if (rate <= hi[i]) return cd[i];
    return -1;
  endfunction

  function automatic int exp_code_at(input int k);
    case (k) 0: return 'h34; 1: return 'h44; 2: return 'h54; 3: return 'h84;
      4: return 'h94; 5: return 'h75; default: return 0; endcase
  endfunction

  function automatic int exp_data_at(input int k, input int code);
    if (k >= 1 && k <= 4) return (code << 1) & 'hff;
    if (k == 5) return 4;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Monitor sampled at the falling clock edge
  logic prev_clk = 1'b0, prev_clr = 1'b0, prev_en = 1'b0, pend = 1'b0;
  logic [7:0] cur_code = 8'd0;
  int wr_n = 0, clr_len = 0, clr_fall = -1, en_rise = -1, clk_bad = 0;
  int wc [8];
  int wd [8];

  task automatic mon_clear();
    wr_n = 0; clr_len = 0; clr_fall = -1; en_rise = -1; clk_bad = 0; pend = 1'b0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (tst_clr_o) begin
      clr_len++;
      if (!tst_clk_o) clk_bad++;
    end
    if (prev_clr && !tst_clr_o) clr_fall = cyc;
    if (!prev_en && tst_en_o && en_rise < 0) en_rise = cyc;
    if (prev_clk && !tst_clk_o && tst_en_o) begin cur_code = tst_din_o; pend = 1'b1; end
    if (!prev_clk && tst_clk_o && !tst_en_o && pend) begin
      if (wr_n < 8) begin wc[wr_n] = int'(cur_code); wd[wr_n] = int'(tst_din_o); end
      wr_n++; pend = 1'b0;
    end
    prev_clk = tst_clk_o; prev_clr = tst_clr_o; prev_en = tst_en_o;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  logic [3:0] last_mask = 4'd0;

  task automatic run(input int rate, input int lanes, input int inject);
    int code; bit exp_err; bit got_done; bit got_err; int n;
    code = ref_code(rate);
    exp_err = (code <= 0) || lanes < 1 || lanes > 4;
    mon_clear();
    @(negedge clk);
    rate_i = 12'(rate); lanes_i = 3'(lanes); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after start", busy_o, 1);
    got_done = 0; got_err = 0; n = 0;
    while (!got_done && !got_err && n < 3000) begin
      if (inject == 1 && n == 20) begin rate_i = 12'd1500; lanes_i = 3'd1; start_i = 1'b1; end
      else start_i = 1'b0;
      if (done_o) got_done = 1;
      else if (error_o) got_err = 1;
      else begin @(negedge clk); n++; end
    end
    start_i = 1'b0;
    if (exp_err) begin
      chk(got_err && !got_done, $sformatf("R2 reject rate=%0d lanes=%0d", rate, lanes), got_err, 1);
      chk(wr_n == 0, "R2 no writes", wr_n, 0);
      chk(lane_en_o == last_mask, "R2 lanes unchanged", lane_en_o, last_mask);
      @(negedge clk);
      chk(!error_o && !busy_o, "R7 error pulse one cycle", error_o, 0);
    end else begin
      chk(got_done && !got_err, $sformatf("R7 done rate=%0d lanes=%0d", rate, lanes), got_done, 1);
      chk(wr_n == 7, "R6 write count", wr_n, 7);
      for (int k = 0; k < 7 && k < wr_n; k++) begin
        chk(wc[k] == exp_code_at(k), $sformatf("R6 code %0d", k), wc[k], exp_code_at(k));
        chk(wd[k] == exp_data_at(k, code), $sformatf("R1 R5 data %0d rate=%0d", k, rate),
            wd[k], exp_data_at(k, code));
      end
      last_mask = 4'((1 << lanes) - 1);
      chk(lane_en_o == last_mask, "R3 lane mask", lane_en_o, last_mask);
      chk(turn_dis_o == 4'hF && turn_req_o == 4'h0, "R3 turnaround", {turn_dis_o, turn_req_o}, 'hF0);
      chk(force_rx_o == 4'h0 && force_stop_o == 4'h0, "R3 force cleared",
          {force_rx_o, force_stop_o}, 0);
      chk(clr_len >= CLR_EXP && clr_len <= CLR_EXP + 2, "R4 clear width", clr_len, CLR_EXP);
      chk(clk_bad == 0, "R4 clock high during clear", clk_bad, 0);
      chk(en_rise - clr_fall >= CLR_EXP, "R4 wait after clear", en_rise - clr_fall, CLR_EXP);
      @(negedge clk);
      chk(!done_o && !busy_o, "R7 done pulse one cycle", done_o, 0);
    end
  endtask

  task automatic power_off_pulse();
    @(negedge clk); power_off_i = 1'b1;
    @(negedge clk); power_off_i = 1'b0;
    last_mask = 4'd0;
    chk(lane_en_o == 4'd0 && !busy_o, "R9 power off clears lanes", lane_en_o, 0);
    chk(!tst_clr_o && !tst_en_o, "R9 clear and enable dropped", {tst_clr_o, tst_en_o}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(lane_en_o == 0 && turn_req_o == 0 && turn_dis_o == 0, "R10 lane vectors",
        {lane_en_o, turn_req_o, turn_dis_o}, 0);
    chk(force_rx_o == 4'hF && force_stop_o == 4'hF, "R10 force set", {force_rx_o, force_stop_o}, 'hFF);
    chk(!busy_o && !done_o && !error_o && !tst_clr_o && !tst_en_o && !tst_clk_o,
        "R10 control idle", {busy_o, done_o, error_o, tst_clr_o, tst_en_o, tst_clk_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed boundaries of R1 and R2
    run(90, 4, 0);
    run(89, 2, 0);
    run(0, 2, 0);
    run(99, 1, 0);
    run(100, 3, 0);
    run(129, 2, 0);
    run(130, 4, 0);
    run(1499, 4, 0);
    run(1500, 2, 0);
    run(1501, 2, 0);
    run(400, 0, 0);
    run(400, 5, 0);
    // R8 second start mid-sequence must not disturb the first request
    run(300, 3, 1);
    // R9 power-off after completion and in the middle of the clear hold
    power_off_pulse();
    mon_clear();
    @(negedge clk); rate_i = 12'd700; lanes_i = 3'd4; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (50) @(negedge clk);
    power_off_pulse();
    repeat (600) @(negedge clk);
    chk(wr_n == 0 && !done_o, "R9 abandoned sequence writes nothing", wr_n, 0);

    // Random requests
    for (int t = 0; t < 25; t++) begin
      int r; int l;
      r = int'($urandom_range(0, 1600));
      l = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 7)) : int'($urandom_range(1, 4));
      run(r, l, 0);
      if (t % 8 == 7) power_off_pulse();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule